// File: doc/BRIEF.md
# Iterative Virtual-PC Indirect Target Predictor

This block predicts where an indirect branch will go without owning any target table of its own. It recasts the branch as a chain of virtual conditional branches. For each link it forms a virtual PC and a virtual global history, and it presents them on a lookup port. That port feeds the chip's existing direction predictor and branch target buffer (BTB). The answers return one cycle after a lookup is issued. A not-taken answer moves the walk to the next virtual branch. A taken answer ends the walk, and the BTB target for that virtual PC becomes the prediction.

The walk gives up in two cases: when the BTB misses on the current virtual PC, or when all `MAX_ITER` virtual branches have answered not-taken. In both cases the result carries a give-up flag, which the front end treats as a stall. Every result reports the iteration number at which the walk ended, for use when the branch retires.

The block takes one request at a time through a valid/ready handshake. It holds each result on a valid/ready output until that result is consumed. A new lookup can issue every cycle, because the next virtual PC and history do not depend on earlier answers. Issue stops in the same cycle as the answer that ends the walk, so no lookup past the deciding one is ever sent.

Top module: `vpc_iter_pred`

## Requirements
- R1: The first lookup of a request (iteration 0) presents the request PC unchanged as the virtual PC and the request global history unchanged as the virtual history.
- R2: Lookup k presents virtual PC = request PC XOR H(k). H(k) is the low PC_W bits of the 32-bit product k * 0x9E3779B9, so H(0) = 0 and every H(k) for k < MAX_ITER is distinct. `lk_iter` carries k.
- R3: Lookup k presents virtual history = request history shifted left by k, with zeros filling from the bottom (for example 1111 becomes 1110 and then 1100).
- R4: Lookups go out on consecutive cycles, one per cycle, starting the cycle after the request is accepted. The answer to a lookup (`dir_taken`, `btb_hit`, `btb_target`) is expected exactly one cycle after that lookup is issued.
- R5: If the answer for iteration k has `btb_hit`=1 and `dir_taken`=1, the result has `res_taken`=1, `res_target` equal to the returned target, and `res_iter`=k. Exactly k+1 lookups are issued for the request.
- R6: If the answer for iteration k has `btb_hit`=0, the walk gives up: `res_taken`=0 and `res_iter`=k, whatever `dir_taken` says. Exactly k+1 lookups are issued for the request.
- R7: If all MAX_ITER answers are not-taken with BTB hits, the walk gives up with `res_taken`=0 and `res_iter`=MAX_ITER-1, after exactly MAX_ITER lookups.
- R8: `res_valid` rises in the cycle after the deciding answer. The result fields stay stable, and `res_valid` stays high, until a cycle with `res_ready`=1.
- R9: `req_ready` is high only when no walk is running and no result is pending. While `req_ready` is high, `lk_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Prediction request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_pc | input | PC_W | PC of the indirect branch |
| req_ghr | input | GHR_W | Current global history |
| lk_valid | output | 1 | Lookup issued this cycle |
| lk_vpc | output | PC_W | Virtual PC for the lookup |
| lk_vghr | output | GHR_W | Virtual history for the lookup |
| lk_iter | output | ITER_W | Iteration number of the lookup |
| dir_taken | input | 1 | Direction answer for the lookup issued last cycle |
| btb_hit | input | 1 | BTB hit for the lookup issued last cycle |
| btb_target | input | PC_W | BTB target for the lookup issued last cycle |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_taken | output | 1 | 1: target predicted; 0: give up and stall |
| res_target | output | PC_W | Predicted indirect target |
| res_iter | output | ITER_W | Iteration at which the walk ended |

## Verification
The walk is swept over every pairing of the iteration where the direction answer first turns taken and the iteration where the BTB first misses, each ranging over 0 to MAX_ITER (MAX_ITER meaning "never"). This separates a hit from a miss-driven give-up and from running out of iterations. The case where both land on the same iteration shows that a miss takes priority. The number of lookups issued and the cycle in which the result appears show that issue stops exactly at the deciding answer. Each case uses a different PC and history, so the per-iteration virtual PC and history checks cannot pass on a stale or constant value. Some cases hold `res_ready` low to check that the result is held and that new requests are refused.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  localparam logic [31:0] VPC_HASH_MULT = 32'h9E37_79B9;

  // Per-iteration hash constant; an odd multiplier keeps entries distinct.
  function automatic logic [31:0] vpc_hash(input int unsigned idx);
    logic [31:0] prod;
    prod = 32'(idx) * VPC_HASH_MULT;
    return prod;
  endfunction

endpackage

// File: rtl/vpc_issue.sv
module vpc_issue #(
  parameter int PC_W     = 32,
  parameter int GHR_W    = 16,
  parameter int MAX_ITER = 12,
  parameter int ITER_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PC_W-1:0]   start_pc,
  input  logic [GHR_W-1:0]  start_ghr,
  input  logic              stop,
  output logic              busy,
  output logic              lk_valid,
  output logic [PC_W-1:0]   lk_vpc,
  output logic [GHR_W-1:0]  lk_vghr,
  output logic [ITER_W-1:0] lk_iter
);

  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(MAX_ITER - 1);

  logic              active_q, active_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [GHR_W-1:0]  vghr_q, vghr_d;

  logic [PC_W-1:0] hash_tab [MAX_ITER];

  generate
    for (genvar g = 0; g < MAX_ITER; g++) begin : g_hash
      localparam logic [31:0] HV = vpc_pkg::vpc_hash(g);
      assign hash_tab[g] = HV[PC_W-1:0];
    end
  endgenerate

  assign busy     = active_q;
  assign lk_valid = active_q & ~stop;
  assign lk_vpc   = pc_q ^ hash_tab[iter_q];
  assign lk_vghr  = vghr_q;
  assign lk_iter  = iter_q;

  always_comb begin
    active_d = active_q;
    iter_d   = iter_q;
    pc_d     = pc_q;
    vghr_d   = vghr_q;
    if (start) begin
      active_d = 1'b1;
      iter_d   = '0;
      pc_d     = start_pc;
      vghr_d   = start_ghr;
    end else if (lk_valid) begin
      iter_d = iter_q + 1'b1;
      vghr_d = vghr_q << 1;
      if (iter_q == LAST_ITER) active_d = 1'b0;
    end else if (stop) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      iter_q   <= '0;
      pc_q     <= '0;
      vghr_q   <= '0;
    end else begin
      active_q <= active_d;
      iter_q   <= iter_d;
      pc_q     <= pc_d;
      vghr_q   <= vghr_d;
    end
  end

  // R3: consecutive lookups see the history shifted by one with a zero fill
  p_vghr_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(lk_valid)) |-> (lk_vghr == ($past(lk_vghr) << 1)));

  // R7: never issues beyond the last iteration
  p_iter_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_iter <= LAST_ITER));

  // R4: back-to-back lookups advance the iteration by exactly one
  p_iter_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(lk_valid)) |-> (lk_iter == $past(lk_iter) + 1'b1));

endmodule

// File: rtl/vpc_resolve.sv
module vpc_resolve #(
  parameter int PC_W     = 32,
  parameter int MAX_ITER = 12,
  parameter int ITER_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ITER_W-1:0] lk_iter,
  input  logic              dir_taken,
  input  logic              btb_hit,
  input  logic [PC_W-1:0]   btb_target,
  output logic              pend,
  output logic              done,
  output logic              done_taken,
  output logic [PC_W-1:0]   done_target,
  output logic [ITER_W-1:0] done_iter
);

  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(MAX_ITER - 1);

  logic              pend_q, pend_d;
  logic [ITER_W-1:0] iter_q, iter_d;

  assign pend = pend_q;

  always_comb begin
    done        = pend_q & (~btb_hit | dir_taken | (iter_q == LAST_ITER));
    done_taken  = pend_q & btb_hit & dir_taken;
    done_target = btb_target;
    done_iter   = iter_q;
    pend_d      = lk_valid;
    iter_d      = lk_valid ? lk_iter : iter_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      iter_q <= '0;
    end else begin
      pend_q <= pend_d;
      iter_q <= iter_d;
    end
  end

  // R4: every issued lookup is awaited in the following cycle
  p_pend_after_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pend_q);

  // R6: a BTB miss on an awaited answer never yields a taken result
  p_miss_gives_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !btb_hit) |-> (done && !done_taken));

endmodule

// File: rtl/vpc_result.sv
module vpc_result #(
  parameter int PC_W   = 32,
  parameter int ITER_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_taken,
  input  logic [PC_W-1:0]   load_target,
  input  logic [ITER_W-1:0] load_iter,
  input  logic              res_ready,
  output logic              res_valid,
  output logic              res_taken,
  output logic [PC_W-1:0]   res_target,
  output logic [ITER_W-1:0] res_iter
);

  logic              valid_q, valid_d;
  logic              taken_q;
  logic [PC_W-1:0]   target_q;
  logic [ITER_W-1:0] iter_q;

  always_comb begin
    valid_d = valid_q;
    if (load)                      valid_d = 1'b1;
    else if (valid_q && res_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q  <= 1'b0;
      target_q <= '0;
      iter_q   <= '0;
    end else if (load) begin
      taken_q  <= load_taken;
      target_q <= load_target;
      iter_q   <= load_iter;
    end
  end

  assign res_valid  = valid_q;
  assign res_taken  = taken_q;
  assign res_target = target_q;
  assign res_iter   = iter_q;

  // R8: an unconsumed result stays put
  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_taken) && $stable(res_target) && $stable(res_iter)));

endmodule

// File: rtl/vpc_iter_pred.sv
module vpc_iter_pred #(
  parameter int PC_W     = 32,
  parameter int GHR_W    = 16,
  parameter int MAX_ITER = 12,
  localparam int ITER_W  = (MAX_ITER > 2) ? $clog2(MAX_ITER) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [GHR_W-1:0]  req_ghr,
  output logic              lk_valid,
  output logic [PC_W-1:0]   lk_vpc,
  output logic [GHR_W-1:0]  lk_vghr,
  output logic [ITER_W-1:0] lk_iter,
  input  logic              dir_taken,
  input  logic              btb_hit,
  input  logic [PC_W-1:0]   btb_target,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_taken,
  output logic [PC_W-1:0]   res_target,
  output logic [ITER_W-1:0] res_iter
);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic              start, walk_busy, pend, done, done_taken;
  logic [PC_W-1:0]   done_target;
  logic [ITER_W-1:0] done_iter;

  assign req_ready = rst_n & ~(walk_busy | pend | res_valid);
  assign start     = req_valid & req_ready;

  vpc_issue #(
    .PC_W(PC_W), .GHR_W(GHR_W), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)
  ) issue_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(req_pc),
    .start_ghr(req_ghr), .stop(done), .busy(walk_busy),
    .lk_valid(lk_valid), .lk_vpc(lk_vpc), .lk_vghr(lk_vghr), .lk_iter(lk_iter)
  );

  vpc_resolve #(
    .PC_W(PC_W), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)
  ) resolve_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_iter(lk_iter),
    .dir_taken(dir_taken), .btb_hit(btb_hit), .btb_target(btb_target),
    .pend(pend), .done(done), .done_taken(done_taken),
    .done_target(done_target), .done_iter(done_iter)
  );

  vpc_result #(
    .PC_W(PC_W), .ITER_W(ITER_W)
  ) result_i (
    .clk(clk), .rst_n(rst_n), .load(done), .load_taken(done_taken),
    .load_target(done_target), .load_iter(done_iter), .res_ready(res_ready),
    .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
    .res_iter(res_iter)
  );

  // R9: no lookup leaves an idle block
  p_no_lookup_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lk_valid);

  // R1: the first lookup after acceptance carries the request PC and history
  p_first_lookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (lk_valid && lk_iter == '0 && lk_vpc == $past(req_pc) && lk_vghr == $past(req_ghr)));

  // R8: a deciding answer raises the result valid in the next cycle
  p_result_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> res_valid);

endmodule

// File: tb/vpc_iter_pred_tb_top.sv
module vpc_iter_pred_tb_top;

  localparam int PC_W   = 32;
  localparam int GHR_W  = 16;
  localparam int MAXI   = 12;
  localparam int ITER_W = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [PC_W-1:0]   req_pc = '0;
  logic [GHR_W-1:0]  req_ghr = '0;
  logic              lk_valid;
  logic [PC_W-1:0]   lk_vpc;
  logic [GHR_W-1:0]  lk_vghr;
  logic [ITER_W-1:0] lk_iter;
  logic              dir_taken = 1'b0;
  logic              btb_hit = 1'b0;
  logic [PC_W-1:0]   btb_target = '0;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic              res_taken;
  logic [PC_W-1:0]   res_target;
  logic [ITER_W-1:0] res_iter;

  int checks = 0;
  int errors = 0;
  int hit_k = MAXI;
  int miss_k = MAXI;
  logic [PC_W-1:0] cur_pc = '0;

  always #2.5 clk = ~clk;

  vpc_iter_pred #(.PC_W(PC_W), .GHR_W(GHR_W), .MAX_ITER(MAXI)) dut_i (
    .clk(clk), .rst_ni(rst_ni), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_ghr(req_ghr), .lk_valid(lk_valid), .lk_vpc(lk_vpc),
    .lk_vghr(lk_vghr), .lk_iter(lk_iter), .dir_taken(dir_taken),
    .btb_hit(btb_hit), .btb_target(btb_target), .res_valid(res_valid),
    .res_ready(res_ready), .res_taken(res_taken), .res_target(res_target),
    .res_iter(res_iter)
  );

  function automatic logic [PC_W-1:0] hval(input int k);
    logic [31:0] p;
    p = 32'(k) * 32'h9E37_79B9;
    return p[PC_W-1:0];
  endfunction

  function automatic logic [PC_W-1:0] tgt_of(input logic [PC_W-1:0] v);
    return {v[15:0], v[31:16]} ^ 32'h0F0F_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Model of the direction predictor and BTB: answers one cycle after a lookup.
  always @(posedge clk) begin
    if (lk_valid) begin
      int k;
      k = -1;
      for (int j = 0; j < MAXI; j++)
        if ((cur_pc ^ hval(j)) == lk_vpc) k = j;
      dir_taken  <= (k == hit_k);
      btb_hit    <= (k != miss_k);
      btb_target <= tgt_of(lk_vpc);
    end
  end

  task automatic run_case(input int hk, input int mk, input logic [PC_W-1:0] pc,
                          input logic [GHR_W-1:0] ghr, input bit bp);
    int n;
    int cyc;
    int r;
    bit exp_taken;
    @(negedge clk);
    hit_k = hk; miss_k = mk; cur_pc = pc;
    res_ready = ~bp;
    chk(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_pc = pc; req_ghr = ghr;
    @(negedge clk);
    req_valid = 1'b0;
    if (mk < MAXI && mk <= hk) begin r = mk; exp_taken = 1'b0; end
    else if (hk < MAXI)        begin r = hk; exp_taken = 1'b1; end
    else                       begin r = MAXI - 1; exp_taken = 1'b0; end
    n = 0; cyc = 0;
    while (!res_valid && cyc < 40) begin
      chk(req_ready == 1'b0, "R9 busy refuses", req_ready, 0);
      if (lk_valid) begin
        if (n == 0) begin
          chk(lk_vpc == pc, "R1 first vpc", lk_vpc, pc);
          chk(lk_vghr == ghr, "R1 first vghr", lk_vghr, ghr);
        end else begin
          chk(lk_vpc == (pc ^ hval(n)), "R2 vpc", lk_vpc, pc ^ hval(n));
          chk(lk_vghr == GHR_W'(ghr << n), "R3 vghr", lk_vghr, GHR_W'(ghr << n));
        end
        chk(int'(lk_iter) == n, "R2 lk_iter", lk_iter, n);
        chk(cyc == n, "R4 one lookup per cycle", cyc, n);
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    chk(res_valid == 1'b1, "R8 result appears", res_valid, 1);
    chk(cyc == r + 2, "R8 result timing", cyc, r + 2);
    if (exp_taken) begin
      chk(res_taken == 1'b1, "R5 taken", res_taken, 1);
      chk(res_target == tgt_of(pc ^ hval(r)), "R5 target", res_target, tgt_of(pc ^ hval(r)));
      chk(int'(res_iter) == r, "R5 hit iteration", res_iter, r);
      chk(n == r + 1, "R5 lookup count", n, r + 1);
    end else if (mk < MAXI && mk <= hk) begin
      chk(res_taken == 1'b0, "R6 give up on miss", res_taken, 0);
      chk(int'(res_iter) == r, "R6 miss iteration", res_iter, r);
      chk(n == r + 1, "R6 lookup count", n, r + 1);
    end else begin
      chk(res_taken == 1'b0, "R7 give up at limit", res_taken, 0);
      chk(int'(res_iter) == MAXI - 1, "R7 last iteration", res_iter, MAXI - 1);
      chk(n == MAXI, "R7 lookup count", n, MAXI);
    end
    if (bp) begin
      logic [PC_W-1:0] t0;
      logic [ITER_W-1:0] i0;
      logic k0;
      t0 = res_target; i0 = res_iter; k0 = res_taken;
      for (int w = 0; w < 3; w++) begin
        @(negedge clk);
        chk(res_valid && res_target == t0 && res_iter == i0 && res_taken == k0,
            "R8 held under backpressure", res_target, t0);
        chk(req_ready == 1'b0, "R9 refuses with result pending", req_ready, 0);
        chk(lk_valid == 1'b0, "R5 no lookup after decision", lk_valid, 0);
      end
      res_ready = 1'b1;
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 consumed", res_valid, 0);
    chk(req_ready == 1'b1, "R9 idle again", req_ready, 1);
    chk(lk_valid == 1'b0, "R9 no lookup when idle", lk_valid, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(res_valid == 1'b0, "R8 reset result", res_valid, 0);
    chk(lk_valid == 1'b0, "R9 reset lookup", lk_valid, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    for (int hk = 0; hk <= MAXI; hk++) begin
      for (int mk = 0; mk <= MAXI; mk++) begin
        run_case(hk, mk,
                 32'h1000_0040 + 32'(hk) * 32'h0001_1110 + 32'(mk) * 32'h0000_0404,
                 16'hFFFF ^ 16'((hk << 5) | mk),
                 ((hk + mk) % 5) == 0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule